// File: doc/BRIEF.md
# Strand Pause Counter

This unit holds one hardware thread (strand) off the shared core for a cycle count chosen by software, so the other runnable strands get the core. Software writes a 32-bit cycle count through a one-cycle write strobe. The unit divides the count by eight, loads the quotient into an internal down-counter, and asserts a blocked output. The counter steps down once every eight clock cycles. When it runs out, the blocked output drops and a one-cycle done pulse follows.

If the written count is below eight, the strand is held for one cycle only. A disrupting trap or interrupt cancels a pause at once. The blocked output drops combinationally in the same cycle as the trap, and no done pulse is produced. A new write during a pause replaces the remaining time. The scheduler that acts on the blocked output, and the trap logic, are outside this block.

Top module: `spause_unit`

## Requirements
- R1: After reset, `blocked` and `done` are both 0.
- R2: A write of a value v with v >= 8 (taken when `wr_en` is 1 and `trap` is 0 at a clock edge) makes `blocked` 1 from the cycle after that edge. `blocked` stays 1 for exactly 8*floor(v/8) cycles.
- R3: The internal count is bits [31:3] of the written value. A 3-bit prescaler restarts from zero on every accepted write and decrements the count once every 8 cycles.
- R4: A write of a value v with v < 8 makes `blocked` 1 for exactly one cycle.
- R5: When a pause runs out on its own, `done` is 1 for exactly one cycle: the first cycle in which `blocked` is 0 again.
- R6: While `trap` is 1, `blocked` is 0 in that same cycle. A trap during a pause ends the pause for good, and no `done` pulse follows.
- R7: A write in a cycle where `trap` is 1 is ignored. A trap while idle has no effect on `blocked` or `done`.
- R8: A write during an active pause reloads the counter. The new pause then lasts exactly as long as it would from idle, counted from that write.
- R9: The counter is 29 bits wide, so any 32-bit value loads without wrap. A write of 4000 blocks for exactly 4000 cycles, and 0xFFFFFFFF stays blocked until a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pause register write strobe |
| wr_data | input | 32 | Requested pause length in cycles |
| trap | input | 1 | Disrupting trap or interrupt; cancels the pause |
| blocked | output | 1 | Strand is held off the core |
| done | output | 1 | One-cycle pulse when a pause runs out on its own |

## Verification
A write is sampled at a clock edge. `blocked` is due in the cycle after that edge and falls exactly 8*floor(v/8) cycles later, or one cycle later for values below eight. `done` is due in the first cycle after the fall. The effect of `trap` on `blocked` is combinational in its own cycle. The bench drives inputs on falling edges and samples on falling edges. It counts the falling edges on which `blocked` is high and compares that count with the value computed from the written data. It checks `done` at the first low sample and again at the sample after that. For trap cases it samples shortly after raising `trap`, before the next rising edge.

// File: rtl/spause_pkg.sv
package spause_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned GRAN_LOG2 = 3;
  localparam int unsigned CNT_W     = DATA_W - GRAN_LOG2;
endpackage

// File: rtl/spause_prescale.sv
// Granularity prescaler: restarts on clr, advances on adv, and flags
// the last step of each granule as tick.
module spause_prescale #(
  parameter int unsigned W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tick
);
  logic [W-1:0] q, q_d;

  always_comb begin
    q_d = q;
    if (clr)      q_d = '0;
    else if (adv) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign tick = adv && (q == {W{1'b1}});
endmodule

// File: rtl/spause_count.sv
// Granule down-counter with load (highest priority), clear and decrement.
module spause_count #(
  parameter int unsigned W = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero,
  output logic         is_one
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)                  cnt_d = load_val;
    else if (clr)              cnt_d = '0;
    else if (dec && !is_zero)  cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/spause_unit.sv
module spause_unit #(
  parameter int unsigned DATA_W    = spause_pkg::DATA_W,
  parameter int unsigned GRAN_LOG2 = spause_pkg::GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap,
  output logic              blocked,
  output logic              done
);
  localparam int unsigned CNT_W = DATA_W - GRAN_LOG2;

  logic             blk_q, blk_d;
  logic             done_q, done_d;
  logic             load, active, tick, expire;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero, cnt_one;

  // An accepted write needs no trap in the same cycle.
  assign load   = wr_en && !trap;
  assign active = blk_q && !trap;

  spause_prescale #(.W(GRAN_LOG2)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load || trap),
    .adv   (active && !cnt_zero),
    .tick  (tick)
  );

  spause_count #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (wr_data[DATA_W-1:GRAN_LOG2]),
    .clr      (trap),
    .dec      (tick),
    .cnt      (cnt_q),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  // Natural end: short pause (count zero) or the last granule ticking out.
  assign expire = active && !load && (cnt_zero || (tick && cnt_one));

  always_comb begin
    blk_d  = blk_q;
    if (load)        blk_d = 1'b1;
    else if (trap)   blk_d = 1'b0;
    else if (expire) blk_d = 1'b0;
    done_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      blk_q  <= blk_d;
      done_q <= done_d;
    end
  end

  assign blocked = blk_q && !trap;
  assign done    = done_q;
endmodule

// File: rtl/spause_chk.sv
module spause_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned GRAN_LOG2 = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [DATA_W-1:0]           wr_data,
  input logic                        trap,
  input logic                        blocked,
  input logic                        done,
  input logic                        blk,
  input logic [DATA_W-GRAN_LOG2-1:0] cnt
);
  // R2 / R3: an accepted write starts the pause with the shifted value
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trap) |=> (blk && cnt == $past(wr_data[DATA_W-1:GRAN_LOG2])));

  // R3: the count never steps by more than one granule per cycle
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !trap && blk) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  // R4: a zero count while blocked means the block ends at the next edge
  p_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && cnt == '0 && !wr_en) |=> !blk);

  // R5: done follows a blocked cycle and lasts one cycle
  p_done_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(blk) && !blk));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a trap clears the pause and produces no done
  p_trap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (!blk && !done));
  p_trap_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !blocked);
endmodule

bind spause_unit spause_chk #(.DATA_W(DATA_W), .GRAN_LOG2(GRAN_LOG2)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .trap    (trap),
  .blocked (blocked),
  .done    (done),
  .blk     (blk_q),
  .cnt     (cnt_q)
);

// File: tb/sim_spause_unit.sv
module sim_spause_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        trap = 1'b0;
  logic        blocked, done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  spause_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trap(trap), .blocked(blocked), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_len(input logic [31:0] v);
    return (v < 8) ? 1 : 8 * longint'(v >> 3);
  endfunction

  // Write v, measure how many samples blocked stays high, check done.
  task automatic run_pause(input logic [31:0] v, input string req);
    int dur = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    while (blocked && dur < 100000) begin
      dur++;
      @(negedge clk);
    end
    check(dur == exp_len(v), req, dur, exp_len(v));
    check(done == 1'b1, "R5 done at fall", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R5 done single", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(blocked == 1'b0, "R1 blocked", blocked, 0);
    check(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(blocked == 1'b0 && done == 1'b0, "R1 after release", blocked, 0);

    // R2 R3 R4 sweep over small values
    for (int v = 0; v < 136; v++) begin
      if (v < 8) run_pause(v, "R4 short length");
      else       run_pause(v, "R2 R3 length");
    end

    // R9 values in the thousands
    run_pause(32'd4000, "R9 length 4000");
    run_pause(32'd4095, "R9 length 4095");

    // R8 reload during pause
    begin
      int dur = 0;
      @(negedge clk); wr_en = 1'b1; wr_data = 32'd80;
      @(negedge clk); wr_en = 1'b0;
      repeat (19) @(negedge clk);
      check(blocked == 1'b1, "R8 still blocked before reload", blocked, 1);
      wr_en = 1'b1; wr_data = 32'd21;
      @(negedge clk); wr_en = 1'b0;
      while (blocked && dur < 1000) begin dur++; @(negedge clk); end
      check(dur == 16, "R8 reload length", dur, 16);
      check(done == 1'b1, "R8 done after reload", done, 1);
      @(negedge clk);
    end

    // R6 trap mid-pause
    @(negedge clk); wr_en = 1'b1; wr_data = 32'd200;
    @(negedge clk); wr_en = 1'b0;
    repeat (30) @(negedge clk);
    check(blocked == 1'b1, "R6 blocked before trap", blocked, 1);
    trap = 1'b1; #1;
    check(blocked == 1'b0, "R6 same-cycle drop", blocked, 0);
    @(negedge clk); trap = 1'b0;
    for (int i = 0; i < 220; i++) begin
      if (blocked || done) begin
        check(1'b0, "R6 no resume or done", {blocked, done}, 0);
        break;
      end
      @(negedge clk);
    end
    check(blocked == 1'b0 && done == 1'b0, "R6 after trap", blocked, 0);

    // R7 write with trap is ignored; trap while idle has no effect
    wr_en = 1'b1; wr_data = 32'd64; trap = 1'b1;
    @(negedge clk); wr_en = 1'b0; trap = 1'b0;
    check(blocked == 1'b0, "R7 write under trap ignored", blocked, 0);
    trap = 1'b1;
    @(negedge clk); trap = 1'b0;
    @(negedge clk);
    check(blocked == 1'b0 && done == 1'b0, "R7 idle trap", done, 0);

    // R9 maximum value does not wrap
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); wr_en = 1'b0;
    repeat (2000) @(negedge clk);
    check(blocked == 1'b1, "R9 max value still blocked", blocked, 1);
    trap = 1'b1;
    @(negedge clk); trap = 1'b0;
    @(negedge clk);
    check(blocked == 1'b0 && done == 1'b0, "R9 max cancelled", blocked, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule